// File: doc/BRIEF.md
# Power-Up Sequencer with Startup Watchdog

This block brings a supply domain and its microcontroller out of power-on in a fixed order. It first enables the DC-DC converter and waits for its power-good flag. Next it enables the first LDO and waits for that LDO's power-ok flag. At that point it releases the LDO1 reset and fires a one-time pulse sequence that loads the one-time-programmable (OTP) latch and then copies it into the pre-regulator register. It also holds the microcontroller in reset for a fixed timeout.

When the microcontroller reset is released, a startup watchdog window opens. A trigger pulse from the microcontroller inside that window requests the Standby state. A window that closes without a trigger puts the microcontroller back into reset for another timeout, followed by a new window. The third consecutive miss gives up and requests Sleep.

From Standby, a Normal-mode command enables LDO2 and LDO3. A one-cycle interrupt reports the first cycle in which both of them are good. If any stage that is already enabled and good loses its flag, the block falls back to its initial state with every enable off.

Top module: `pwrseq_top`

## Requirements
- R1: One cycle after reset (or after a return to the initial state), `dcdc_en_o` rises. `ldo1_en_o` stays low until `dcdc_pg_i` has been sampled high, and it rises on the following cycle.
- R2: `ldo1_rst_o` goes high on the cycle after `ldo1_pok_i` is sampled high. `otp_por_n_o` then goes low one cycle later and stays low for exactly OTP_PULSE (4) cycles.
- R3: `otp_load_o` is high for exactly one cycle, after OTP_GAP (2) cycles in which `otp_por_n_o` has been high again.
- R4: `mcu_rst_n_o` stays low for RST_TIMEOUT cycles, counted from the cycle after `ldo1_pok_i` is sampled high, and then goes high.
- R5: After `mcu_rst_n_o` rises, a window of WDG_WINDOW cycles is open. A `mcu_trig_i` sampled in any of its cycles, including the last one, raises `standby_req_o` on the next cycle, and `mcu_rst_n_o` stays high.
- R6: A window that ends with no trigger drives `mcu_rst_n_o` low on the next cycle for RST_TIMEOUT cycles, then opens a new window.
- R7: The third consecutive missed window raises `sleep_req_o` with `mcu_rst_n_o` held low, and Sleep persists. The 2-bit miss count is cleared by a successful trigger and by a return to the initial state (reset or fault).
- R8: `normal_cmd_i` in Standby sets `ldo2_en_o` and `ldo3_en_o` high and clears `standby_req_o` on the next cycle. In any other state the command has no effect.
- R9: `rails_irq_o` is high for exactly one cycle: the first cycle in the Normal state in which `ldo2_pok_i` and `ldo3_pok_i` are both high. It does not rise again while they stay high.
- R10: A fault sends the block to its initial state with all enables, `ldo1_rst_o`, `mcu_rst_n_o` and the OTP pulse off on the next cycle. A fault is `dcdc_pg_i` low while LDO1 is enabled, `ldo1_pok_i` low after it was reached, or either LDO2/LDO3 flag low after the interrupt.
- R11: During reset, all enables, `ldo1_rst_o`, `mcu_rst_n_o`, `otp_load_o`, both requests and `rails_irq_o` are low, and `otp_por_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dcdc_pg_i | input | 1 | DC-DC power-good |
| ldo1_pok_i | input | 1 | LDO1 power-ok |
| ldo2_pok_i | input | 1 | LDO2 power-ok |
| ldo3_pok_i | input | 1 | LDO3 power-ok |
| mcu_trig_i | input | 1 | Microcontroller startup trigger pulse |
| normal_cmd_i | input | 1 | Normal-mode command |
| dcdc_en_o | output | 1 | DC-DC converter enable |
| ldo1_en_o | output | 1 | LDO1 enable |
| ldo2_en_o | output | 1 | LDO2 enable |
| ldo3_en_o | output | 1 | LDO3 enable |
| ldo1_rst_o | output | 1 | LDO1 domain reset, high = released |
| otp_por_n_o | output | 1 | Active-low OTP power-on pulse |
| otp_load_o | output | 1 | OTP latch to pre-regulator register load strobe |
| mcu_rst_n_o | output | 1 | Microcontroller reset, low = held in reset |
| standby_req_o | output | 1 | Request to enter Standby |
| sleep_req_o | output | 1 | Request to enter Sleep |
| rails_irq_o | output | 1 | One-cycle rails-ready interrupt |

## Verification
The state register updates on the clock edge after an input is sampled, so enables, resets and requests are due one cycle after their cause. The OTP pulse and load strobe are due 1 to 4 cycles and 7 cycles after LDO1 power-ok, and the reset release is due RST_TIMEOUT cycles after it. The interrupt is combinational on the power-ok flags in the Normal state, so it is due in the same cycle as the second flag. The bench drives inputs on the falling edge and samples each output on a later falling edge, counting falling edges from the causing sample. Interrupt checks are made a short delay after the flag changes.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the power-up sequencer.
package pwrseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DCDC    = 3'd1,
        ST_LDO1    = 3'd2,
        ST_RSTWAIT = 3'd3,
        ST_WINDOW  = 3'd4,
        ST_STANDBY = 3'd5,
        ST_NORMAL  = 3'd6,
        ST_SLEEP   = 3'd7
    } seq_state_t;
endpackage

// File: rtl/pwrseq_timer.sv
`timescale 1ns/1ps
// Module: loadable down-counter shared by the reset timeout and the watchdog
// window. Assumes load_val_i is the length minus one; done_o is high while the
// count sits at zero.
module pwrseq_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwrseq_otp.sv
`timescale 1ns/1ps
// Module: OTP strobe generator. After start_i it waits one cycle, drives the
// active-low power-on pulse for PULSE cycles, leaves GAP idle cycles, then
// gives a one-cycle load strobe. abort_i cancels a running sequence.
module pwrseq_otp #(
    parameter int PULSE = 4,
    parameter int GAP   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    output logic por_n_o,
    output logic load_o
);
    localparam int LAST = PULSE + GAP + 1;
    localparam int CW   = $clog2(LAST + 1);
    localparam logic [CW-1:0] LAST_C  = CW'(LAST);
    localparam logic [CW-1:0] PULSE_C = CW'(PULSE);

    logic          active_q;
    logic [CW-1:0] cnt_q;

    // Phase counter: runs from 0 to LAST once per start.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            if (cnt_q == LAST_C)
                active_q <= 1'b0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign por_n_o = !(active_q && (cnt_q != '0) && (cnt_q <= PULSE_C));
    assign load_o  = active_q && (cnt_q == LAST_C);
endmodule

// File: rtl/pwrseq_irq.sv
`timescale 1ns/1ps
// Module: rails-ready detector. While armed, flags the first cycle in which
// both power-ok inputs are high; seen_o stays high until disarmed.
module pwrseq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic ok_a_i,
    input  logic ok_b_i,
    output logic irq_o,
    output logic seen_o
);
    logic seen_q;
    logic both_ok;

    assign both_ok = ok_a_i && ok_b_i;

    // Remember that the rails came up; forget when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm_i)
            seen_q <= 1'b0;
        else if (both_ok)
            seen_q <= 1'b1;
    end

    assign irq_o  = arm_i && both_ok && !seen_q;
    assign seen_o = seen_q;
endmodule

// File: rtl/pwrseq_top.sv
`timescale 1ns/1ps
// Module: power-up sequencer top. Orders the rail enables, releases LDO1 reset,
// starts OTP loading, times the microcontroller reset and runs the startup
// watchdog with a limited number of retries. Assumes the power flags are
// synchronous to clk.
module pwrseq_top #(
    parameter int RST_TIMEOUT = 16,
    parameter int WDG_WINDOW  = 24,
    parameter int MISS_LIMIT  = 3,
    parameter int OTP_PULSE   = 4,
    parameter int OTP_GAP     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dcdc_pg_i,
    input  logic ldo1_pok_i,
    input  logic ldo2_pok_i,
    input  logic ldo3_pok_i,
    input  logic mcu_trig_i,
    input  logic normal_cmd_i,
    output logic dcdc_en_o,
    output logic ldo1_en_o,
    output logic ldo2_en_o,
    output logic ldo3_en_o,
    output logic ldo1_rst_o,
    output logic otp_por_n_o,
    output logic otp_load_o,
    output logic mcu_rst_n_o,
    output logic standby_req_o,
    output logic sleep_req_o,
    output logic rails_irq_o
);
    import pwrseq_pkg::*;

    localparam int TMAX = (RST_TIMEOUT > WDG_WINDOW) ? RST_TIMEOUT : WDG_WINDOW;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int MW   = $clog2(MISS_LIMIT + 1);
    localparam logic [TW-1:0] RST_LOAD  = TW'(RST_TIMEOUT - 1);
    localparam logic [TW-1:0] WIN_LOAD  = TW'(WDG_WINDOW - 1);
    localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);

    seq_state_t    state_q, state_d;
    logic [MW-1:0] miss_q;
    logic          tmr_done, tmr_load;
    logic [TW-1:0] tmr_val;
    logic          rails_seen;
    logic          fault;
    logic          ldo1_on, ldo1_good;
    logic          win_miss;

    // Stage groupings used by the fault check and the outputs.
    assign ldo1_on   = (state_q != ST_IDLE) && (state_q != ST_DCDC);
    assign ldo1_good = ldo1_on && (state_q != ST_LDO1);

    // Fault: an enabled stage that had become good has lost its flag.
    assign fault = (ldo1_on && !dcdc_pg_i)
                || (ldo1_good && !ldo1_pok_i)
                || ((state_q == ST_NORMAL) && rails_seen && !(ldo2_pok_i && ldo3_pok_i));

    assign win_miss = (state_q == ST_WINDOW) && tmr_done && !mcu_trig_i;

    // Next-state selection for the sequence.
    always_comb begin
        state_d = state_q;
        if (fault) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:    state_d = ST_DCDC;
                ST_DCDC:    if (dcdc_pg_i) state_d = ST_LDO1;
                ST_LDO1:    if (ldo1_pok_i) state_d = ST_RSTWAIT;
                ST_RSTWAIT: if (tmr_done) state_d = ST_WINDOW;
                ST_WINDOW: begin
                    if (mcu_trig_i)
                        state_d = ST_STANDBY;
                    else if (tmr_done)
                        state_d = (miss_q == MISS_LAST) ? ST_SLEEP : ST_RSTWAIT;
                end
                ST_STANDBY: if (normal_cmd_i) state_d = ST_NORMAL;
                default:    state_d = state_q;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Consecutive-miss counter, cleared on a trigger or in the initial state.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE)
            miss_q <= '0;
        else if (state_q == ST_WINDOW && mcu_trig_i)
            miss_q <= '0;
        else if (win_miss && !fault)
            miss_q <= miss_q + 1'b1;
    end

    // Timer reload on entering a timed state.
    assign tmr_load = (state_d != state_q)
                   && (state_d == ST_RSTWAIT || state_d == ST_WINDOW);
    assign tmr_val  = (state_d == ST_WINDOW) ? WIN_LOAD : RST_LOAD;

    pwrseq_timer #(.W(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    pwrseq_otp #(.PULSE(OTP_PULSE), .GAP(OTP_GAP)) u_otp (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i ((state_q == ST_LDO1) && (state_d == ST_RSTWAIT)),
        .abort_i (fault),
        .por_n_o (otp_por_n_o),
        .load_o  (otp_load_o)
    );

    pwrseq_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (state_q == ST_NORMAL),
        .ok_a_i (ldo2_pok_i),
        .ok_b_i (ldo3_pok_i),
        .irq_o  (rails_irq_o),
        .seen_o (rails_seen)
    );

    // Output decode from the state register.
    assign dcdc_en_o     = (state_q != ST_IDLE);
    assign ldo1_en_o     = ldo1_on;
    assign ldo1_rst_o    = ldo1_good;
    assign ldo2_en_o     = (state_q == ST_NORMAL);
    assign ldo3_en_o     = (state_q == ST_NORMAL);
    assign mcu_rst_n_o   = (state_q == ST_WINDOW) || (state_q == ST_STANDBY)
                        || (state_q == ST_NORMAL);
    assign standby_req_o = (state_q == ST_STANDBY);
    assign sleep_req_o   = (state_q == ST_SLEEP);
endmodule

// File: rtl/pwrseq_checker.sv
`timescale 1ns/1ps
// Module: temporal checks on the sequencer ports, bound to pwrseq_top.
// Assumes the synchronous active-low reset of the top.
module pwrseq_checker (
    input logic clk,
    input logic rst_n,
    input logic dcdc_pg_i,
    input logic ldo2_pok_i,
    input logic ldo3_pok_i,
    input logic dcdc_en_o,
    input logic ldo1_en_o,
    input logic ldo2_en_o,
    input logic ldo1_rst_o,
    input logic otp_por_n_o,
    input logic otp_load_o,
    input logic mcu_rst_n_o,
    input logic standby_req_o,
    input logic sleep_req_o,
    input logic rails_irq_o
);
    p_ldo1_after_pg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ldo1_en_o && !$past(ldo1_en_o)) |-> $past(dcdc_pg_i));

    p_otp_load_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        otp_load_o |=> !otp_load_o);

    p_otp_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        otp_load_o |-> ($past(otp_por_n_o, 1) && $past(otp_por_n_o, 2)
                        && !$past(otp_por_n_o, 3)));

    p_rst_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mcu_rst_n_o) |-> ldo1_rst_o);

    p_req_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(standby_req_o && sleep_req_o));

    p_sleep_holds_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req_o |-> !mcu_rst_n_o);

    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rails_irq_o |=> !rails_irq_o);

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rails_irq_o |-> (ldo2_pok_i && ldo3_pok_i && ldo2_en_o));

    p_pg_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ldo1_en_o && !dcdc_pg_i) |=> !dcdc_en_o);
endmodule

bind pwrseq_top pwrseq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dcdc_pg_i     (dcdc_pg_i),
    .ldo2_pok_i    (ldo2_pok_i),
    .ldo3_pok_i    (ldo3_pok_i),
    .dcdc_en_o     (dcdc_en_o),
    .ldo1_en_o     (ldo1_en_o),
    .ldo2_en_o     (ldo2_en_o),
    .ldo1_rst_o    (ldo1_rst_o),
    .otp_por_n_o   (otp_por_n_o),
    .otp_load_o    (otp_load_o),
    .mcu_rst_n_o   (mcu_rst_n_o),
    .standby_req_o (standby_req_o),
    .sleep_req_o   (sleep_req_o),
    .rails_irq_o   (rails_irq_o)
);

// File: tb/pwrseq_top_tb.sv
`timescale 1ns/1ps
// Directed bench for pwrseq_top: one task per scenario, each checking itself.
module pwrseq_top_tb;
    localparam int RST = 16;
    localparam int WIN = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dcdc_pg = 1'b0, ldo1_pok = 1'b0, ldo2_pok = 1'b0, ldo3_pok = 1'b0;
    logic trig = 1'b0, ncmd = 1'b0;
    logic dcdc_en, ldo1_en, ldo2_en, ldo3_en, ldo1_rst, por_n, otp_load;
    logic mcu_rst_n, stby, slp, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwrseq_top #(.RST_TIMEOUT(RST), .WDG_WINDOW(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .dcdc_pg_i(dcdc_pg), .ldo1_pok_i(ldo1_pok),
        .ldo2_pok_i(ldo2_pok), .ldo3_pok_i(ldo3_pok),
        .mcu_trig_i(trig), .normal_cmd_i(ncmd),
        .dcdc_en_o(dcdc_en), .ldo1_en_o(ldo1_en),
        .ldo2_en_o(ldo2_en), .ldo3_en_o(ldo3_en),
        .ldo1_rst_o(ldo1_rst), .otp_por_n_o(por_n), .otp_load_o(otp_load),
        .mcu_rst_n_o(mcu_rst_n), .standby_req_o(stby), .sleep_req_o(slp),
        .rails_irq_o(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Hold reset with all flags low, check the reset state (R11).
    task automatic t_reset();
        rst_n = 1'b0; dcdc_pg = 0; ldo1_pok = 0; ldo2_pok = 0; ldo3_pok = 0;
        trig = 0; ncmd = 0;
        step(3);
        chk("R11 dcdc_en", dcdc_en, 0);   chk("R11 ldo1_en", ldo1_en, 0);
        chk("R11 ldo2_en", ldo2_en, 0);   chk("R11 ldo1_rst", ldo1_rst, 0);
        chk("R11 por_n", por_n, 1);       chk("R11 load", otp_load, 0);
        chk("R11 mcu_rst_n", mcu_rst_n, 0);
        chk("R11 stby", stby, 0);         chk("R11 slp", slp, 0);
        chk("R11 irq", irq, 0);
        rst_n = 1'b1;
    endtask

    // From reset release up to the first open window (R1..R4, optional R8 ignore).
    task automatic t_powerup(input bit poke_cmd);
        step(1);
        chk("R1 dcdc_en first", dcdc_en, 1);
        chk("R1 ldo1 waits", ldo1_en, 0);
        step(2);
        chk("R1 ldo1 still waits", ldo1_en, 0);
        dcdc_pg = 1;
        step(1);
        chk("R1 ldo1_en after pg", ldo1_en, 1);
        chk("R2 ldo1_rst held", ldo1_rst, 0);
        ldo1_pok = 1;
        for (int k = 0; k <= RST; k++) begin
            step(1);
            ncmd = (poke_cmd && k == 2);
            chk("R2 ldo1_rst", ldo1_rst, 1);
            chk("R2 por_n", por_n, !(k >= 1 && k <= 4));
            chk("R3 load", otp_load, (k == 7));
            chk("R4 mcu_rst_n", mcu_rst_n, (k == RST));
            if (poke_cmd && k == 3) chk("R8 cmd ignored", ldo2_en, 0);
        end
        ncmd = 0;
    endtask

    // Trigger in cycle j of the open window (R5).
    task automatic t_trig(input int j);
        step(j);
        chk("R5 rst_n held in window", mcu_rst_n, 1);
        chk("R5 no early standby", stby, 0);
        trig = 1;
        step(1);
        trig = 0;
        chk("R5 standby_req", stby, 1);
        chk("R5 mcu_rst_n high", mcu_rst_n, 1);
        chk("R5 no sleep", slp, 0);
    endtask

    // Let a window expire (R6), or the final one into Sleep (R7).
    task automatic t_miss(input bit last);
        step(WIN - 1);
        chk("R6 window still open", mcu_rst_n, 1);
        step(1);
        chk("R6 reset reasserted", mcu_rst_n, 0);
        if (last) begin
            chk("R7 sleep_req", slp, 1);
            chk("R7 no standby", stby, 0);
            trig = 1; step(4); trig = 0;
            chk("R7 sleep persists", slp, 1);
            chk("R7 rst held in sleep", mcu_rst_n, 0);
        end else begin
            chk("R7 no sleep yet", slp, 0);
            step(RST - 1);
            chk("R6 reset timeout", mcu_rst_n, 0);
            step(1);
            chk("R6 new window", mcu_rst_n, 1);
        end
    endtask

    // Normal command, rails interrupt, then a rail fault (R8, R9, R10).
    task automatic t_normal();
        ncmd = 1; step(1); ncmd = 0;
        chk("R8 ldo2_en", ldo2_en, 1);  chk("R8 ldo3_en", ldo3_en, 1);
        chk("R8 standby cleared", stby, 0);
        ldo2_pok = 1; #1;
        chk("R9 no irq on one flag", irq, 0);
        step(1); ldo3_pok = 1; #1;
        chk("R9 irq on both", irq, 1);
        step(1);
        chk("R9 irq single cycle", irq, 0);
        step(2);
        chk("R9 no repeat", irq, 0);
        ldo2_pok = 0;
        step(1);
        chk("R10 ldo2 loss ldo2_en", ldo2_en, 0);
        chk("R10 ldo2 loss dcdc_en", dcdc_en, 0);
        chk("R10 ldo2 loss rst", mcu_rst_n, 0);
    endtask

    // LDO1 flag lost during the reset timeout (R10), then restart (R1).
    task automatic t_fault_ldo1();
        step(1); dcdc_pg = 1; step(1); ldo1_pok = 1;
        step(2);
        ldo1_pok = 0;
        step(1);
        chk("R10 ldo1 loss ldo1_en", ldo1_en, 0);
        chk("R10 ldo1 loss dcdc_en", dcdc_en, 0);
        chk("R10 ldo1 loss ldo1_rst", ldo1_rst, 0);
        chk("R10 otp aborted", por_n, 1);
        step(1);
        chk("R1 restart dcdc_en", dcdc_en, 1);
        step(6);
        chk("R10 no otp after abort", por_n, 1);
    endtask

    initial begin
        t_reset();  t_powerup(1'b1); t_trig(3); t_normal();
        t_reset();  t_powerup(1'b0); t_trig(WIN - 1);
        t_reset();  t_powerup(1'b0); t_miss(0); t_miss(0); t_miss(1);
        t_reset();  t_powerup(1'b0); t_miss(0); t_miss(0); t_trig(0);
        t_reset();  t_fault_ldo1();
        t_reset();  t_powerup(1'b0);
        dcdc_pg = 0; step(1);
        chk("R10 pg loss dcdc_en", dcdc_en, 0);
        chk("R10 pg loss rst", mcu_rst_n, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule